// File: doc/BRIEF.md
# Virtual Interrupt Pending Update with Doorbell

This block takes one request at a time to set or clear the pending state of a virtual message-signalled interrupt. A request carries an interrupt ID, the address of the virtual pending table it belongs to, a doorbell ID and a level. When the request is accepted, the block decides whether the target virtual CPU is resident on this interrupt router. The virtual CPU is resident when the scheduled-table register is valid and holds that same table address. The block then updates the pending bit in memory with a read-modify-write of one byte. The memory port is one byte wide.

When the virtual CPU is resident, the block keeps the cached best-pending record current. A newly set bit is compared alone against the record, using its configuration byte. A newly cleared bit starts a full rescan only if the cleared ID is the cached best. The rescan is done by an external scanner, which the block drives through a request/done handshake.

When the virtual CPU is not resident, the pending bit is still written. The block also raises the doorbell ID as a physical interrupt, which lets the hypervisor reschedule the virtual CPU.

Top module: `vlpi_deliver`

## Requirements
- R1: The request is treated as resident only when `vpe_valid` is 1 and `vpe_tbl_addr` equals `req_tbl_addr`, both sampled at acceptance. A request that is not resident never changes `best_id`/`best_prio`.
- R2: Out-of-range drop. A resident request whose ID is at or above 2^(`vcfg_idbits`+1) is dropped: it makes no memory access, raises no doorbell and finishes with `done_changed`=0.
- R3: Pending-bit update.
  - The pending bit sits in the byte at table address + ID/8, at bit position ID mod 8.
  - The byte is read first. It is written back only when that bit differs from the requested level, and only that bit is changed.
  - `done_changed` is 1 exactly when the write took place.
- R4: Best-record update on a new set.
  - After reset the record holds `best_id`=0 and `best_prio`=0xFF, where 0xFF means nothing is pending.
  - When a resident request newly sets its bit, the block reads the configuration byte at `vcfg_base` + (ID − 8192). Bit 0 of that byte is the enable, and the priority is the byte with its two low bits cleared.
  - An enabled ID replaces the record when its priority is lower than the recorded one, or when the priorities are equal and its ID is at or below the recorded ID.
- R5: Rescan on a clear.
  - When a resident request newly clears the bit of the ID equal to `best_id`, `scan_req` rises and stays high until `scan_done`. The record is then loaded from `scan_id`/`scan_prio`.
  - Clearing any other ID, or a clear that changes no bit, leaves the record alone and starts no rescan.
- R6: Doorbell conditions.
  - A doorbell fires only when all four of these hold: the request is not resident, the level is 1, the doorbell ID is not 1023, and `lpi_enable` is 1.
  - It is a one-cycle `bell_valid` pulse carrying the doorbell ID, given in the `done` cycle.
  - It fires whether or not the pending bit changed.
- R7: The pending-table write also happens for requests that are not resident, at the request's own table address.
- R8: Handshakes and busy.
  - A request is accepted when `req_valid` is 1 and `busy` is 0. `busy` is high from the next cycle up to and including the one-cycle `done` pulse.
  - The memory port has at most one byte access outstanding. A request is held stable while `mem_valid` is 1 and `mem_ready` is 0, and read data returns on `mem_rvalid`.
- R9: Reset state. After reset, `busy`, `done`, `mem_valid`, `scan_req` and `bell_valid` are 0, and the record reads 0/0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_id | input | ID_W | Virtual interrupt ID |
| req_tbl_addr | input | AW | Virtual pending table address of the request |
| req_bell_id | input | ID_W | Doorbell physical interrupt ID (1023 = none) |
| req_level | input | 1 | 1 = set pending, 0 = clear |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| done_changed | output | 1 | Pending bit was flipped (valid with done) |
| vpe_valid | input | 1 | Scheduled-table register valid |
| vpe_tbl_addr | input | AW | Pending table address of the scheduled virtual CPU |
| vcfg_base | input | AW | Virtual configuration table base |
| vcfg_idbits | input | 5 | ID width minus one of the virtual tables |
| lpi_enable | input | 1 | Physical message interrupts enabled |
| mem_valid | output | 1 | Memory access request |
| mem_write | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Byte address |
| mem_wdata | output | 8 | Write byte |
| mem_ready | input | 1 | Memory accepts the access |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 8 | Read byte |
| best_id | output | ID_W | Cached best pending ID |
| best_prio | output | 8 | Cached best priority (0xFF = none) |
| scan_req | output | 1 | Full rescan request |
| scan_done | input | 1 | Rescan finished, result valid |
| scan_id | input | ID_W | Rescan best ID |
| scan_prio | input | 8 | Rescan best priority |
| bell_valid | output | 1 | Doorbell pulse |
| bell_id | output | ID_W | Doorbell physical interrupt ID |

## Verification
Completion of a pending-bit flip (`done` with `done_changed`) and the doorbell pulse can fall in the same cycle. This happens when a request that is not resident newly sets its bit with a real doorbell ID and message interrupts enabled. The bench provokes it with a table address that differs from the scheduled one, and also with the scheduled address while the valid flag is low. It judges both outputs in the single `done` cycle. It also covers the opposite pairings: a doorbell with no bit change, a changed bit with the spurious doorbell ID, and a changed bit with interrupts disabled. These show that the two results are decided independently.

// File: rtl/vlpi_pkg.sv
package vlpi_pkg;

  localparam int unsigned SPURIOUS_ID = 1023;
  localparam logic [7:0]  NO_PRIO     = 8'hFF;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RD_PEND, ST_WT_PEND, ST_WR_PEND,
    ST_RD_CFG, ST_WT_CFG, ST_SCAN, ST_FINISH
  } vst_e;

  function automatic logic is_resident(input logic sched_valid,
                                       input logic [63:0] sched_addr,
                                       input logic [63:0] req_addr);
    return sched_valid && (sched_addr == req_addr);
  endfunction

  function automatic logic id_in_range(input logic [31:0] id, input logic [4:0] idbits);
    return (id >> (idbits + 6'd1)) == 32'd0;
  endfunction

  function automatic logic [31:0] byte_off(input logic [31:0] id);
    return id >> 3;
  endfunction

  function automatic logic [2:0] bit_sel(input logic [31:0] id);
    return id[2:0];
  endfunction

  function automatic logic [7:0] entry_prio(input logic [7:0] entry);
    return {entry[7:2], 2'b00};
  endfunction

  function automatic logic beats_best(input logic [7:0] entry, input logic [31:0] id,
                                      input logic [7:0] bprio, input logic [31:0] bid);
    logic [7:0] p;
    p = entry_prio(entry);
    return entry[0] && ((p < bprio) || ((p == bprio) && (id <= bid)));
  endfunction

endpackage

// File: rtl/vlpi_best_rec.sv
module vlpi_best_rec
  import vlpi_pkg::*;
#(
  parameter int ID_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            eval_en,
  input  logic [ID_W-1:0] eval_id,
  input  logic [7:0]      eval_entry,
  input  logic            load_en,
  input  logic [ID_W-1:0] load_id,
  input  logic [7:0]      load_prio,
  output logic [ID_W-1:0] best_id,
  output logic [7:0]      best_prio
);

  logic wins;
  assign wins = beats_best(eval_entry, 32'(eval_id), best_prio, 32'(best_id));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      best_id   <= '0;
      best_prio <= NO_PRIO;
    end else if (load_en) begin
      best_id   <= load_id;
      best_prio <= load_prio;
    end else if (eval_en && wins) begin
      best_id   <= eval_id;
      best_prio <= entry_prio(eval_entry);
    end
  end

endmodule

// File: rtl/vlpi_ctrl.sv
module vlpi_ctrl
  import vlpi_pkg::*;
#(
  parameter int ID_W      = 16,
  parameter int AW        = 32,
  parameter int LPI_FIRST = 8192
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  input  logic [ID_W-1:0] req_id,
  input  logic [AW-1:0]   req_tbl_addr,
  input  logic [ID_W-1:0] req_bell_id,
  input  logic            req_level,
  input  logic            vpe_valid,
  input  logic [AW-1:0]   vpe_tbl_addr,
  input  logic [AW-1:0]   vcfg_base,
  input  logic [4:0]      vcfg_idbits,
  input  logic            lpi_enable,
  output logic            mem_valid,
  output logic            mem_write,
  output logic [AW-1:0]   mem_addr,
  output logic [7:0]      mem_wdata,
  input  logic            mem_ready,
  input  logic            mem_rvalid,
  input  logic [7:0]      mem_rdata,
  input  logic [ID_W-1:0] best_id,
  output logic            scan_req,
  input  logic            scan_done,
  output logic            rec_eval,
  output logic            rec_load,
  output logic [ID_W-1:0] cur_id,
  output logic            busy,
  output logic            done,
  output logic            done_changed,
  output logic            bell_valid,
  output logic [ID_W-1:0] bell_id,
  output logic            resident
);

  vst_e            state;
  logic [ID_W-1:0] c_id;
  logic [AW-1:0]   c_addr;
  logic [ID_W-1:0] c_bell;
  logic            c_level;
  logic            c_res;
  logic            c_changed;
  logic [7:0]      c_wbyte;
  logic            accept_res;
  logic            bit_match;

  assign accept_res = is_resident(vpe_valid, 64'(vpe_tbl_addr), 64'(req_tbl_addr));
  assign bit_match  = (mem_rdata[bit_sel(32'(c_id))] == c_level);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      c_id      <= '0;
      c_addr    <= '0;
      c_bell    <= '0;
      c_level   <= 1'b0;
      c_res     <= 1'b0;
      c_changed <= 1'b0;
      c_wbyte   <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (req_valid) begin
          c_id      <= req_id;
          c_addr    <= req_tbl_addr;
          c_bell    <= req_bell_id;
          c_level   <= req_level;
          c_res     <= accept_res;
          c_changed <= 1'b0;
          if (accept_res && !id_in_range(32'(req_id), vcfg_idbits)) state <= ST_FINISH;
          else state <= ST_RD_PEND;
        end
        ST_RD_PEND: if (mem_ready) state <= ST_WT_PEND;
        ST_WT_PEND: if (mem_rvalid) begin
          if (bit_match) state <= ST_FINISH;
          else begin
            c_wbyte   <= mem_rdata ^ (8'h01 << bit_sel(32'(c_id)));
            c_changed <= 1'b1;
            state     <= ST_WR_PEND;
          end
        end
        ST_WR_PEND: if (mem_ready) begin
          if (c_res && c_level)               state <= ST_RD_CFG;
          else if (c_res && c_id == best_id)  state <= ST_SCAN;
          else                                state <= ST_FINISH;
        end
        ST_RD_CFG: if (mem_ready)  state <= ST_WT_CFG;
        ST_WT_CFG: if (mem_rvalid) state <= ST_FINISH;
        ST_SCAN:   if (scan_done)  state <= ST_FINISH;
        default:   state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    mem_valid = (state == ST_RD_PEND) || (state == ST_WR_PEND) || (state == ST_RD_CFG);
    mem_write = (state == ST_WR_PEND);
    if (state == ST_RD_CFG) mem_addr = vcfg_base + AW'(c_id) - AW'(LPI_FIRST);
    else                    mem_addr = c_addr + AW'(byte_off(32'(c_id)));
  end

  assign mem_wdata    = c_wbyte;
  assign scan_req     = (state == ST_SCAN);
  assign rec_eval     = (state == ST_WT_CFG) && mem_rvalid;
  assign rec_load     = (state == ST_SCAN) && scan_done;
  assign cur_id       = c_id;
  assign busy         = (state != ST_IDLE);
  assign done         = (state == ST_FINISH);
  assign done_changed = done && c_changed;
  assign bell_valid   = done && !c_res && c_level && lpi_enable &&
                        (32'(c_bell) != SPURIOUS_ID);
  assign bell_id      = c_bell;
  assign resident     = c_res;

endmodule

// File: rtl/vlpi_deliver.sv
module vlpi_deliver #(
  parameter int ID_W      = 16,
  parameter int AW        = 32,
  parameter int LPI_FIRST = 8192
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  input  logic [ID_W-1:0] req_id,
  input  logic [AW-1:0]   req_tbl_addr,
  input  logic [ID_W-1:0] req_bell_id,
  input  logic            req_level,
  output logic            busy,
  output logic            done,
  output logic            done_changed,
  input  logic            vpe_valid,
  input  logic [AW-1:0]   vpe_tbl_addr,
  input  logic [AW-1:0]   vcfg_base,
  input  logic [4:0]      vcfg_idbits,
  input  logic            lpi_enable,
  output logic            mem_valid,
  output logic            mem_write,
  output logic [AW-1:0]   mem_addr,
  output logic [7:0]      mem_wdata,
  input  logic            mem_ready,
  input  logic            mem_rvalid,
  input  logic [7:0]      mem_rdata,
  output logic [ID_W-1:0] best_id,
  output logic [7:0]      best_prio,
  output logic            scan_req,
  input  logic            scan_done,
  input  logic [ID_W-1:0] scan_id,
  input  logic [7:0]      scan_prio,
  output logic            bell_valid,
  output logic [ID_W-1:0] bell_id
);

  logic            ev_eval;
  logic            ev_load;
  logic            ev_resident;
  logic [ID_W-1:0] ev_id;

  vlpi_ctrl #(.ID_W(ID_W), .AW(AW), .LPI_FIRST(LPI_FIRST)) u_ctrl (
    .clk, .rst_n,
    .req_valid, .req_id, .req_tbl_addr, .req_bell_id, .req_level,
    .vpe_valid, .vpe_tbl_addr, .vcfg_base, .vcfg_idbits, .lpi_enable,
    .mem_valid, .mem_write, .mem_addr, .mem_wdata, .mem_ready, .mem_rvalid, .mem_rdata,
    .best_id, .scan_req, .scan_done,
    .rec_eval(ev_eval), .rec_load(ev_load), .cur_id(ev_id),
    .busy, .done, .done_changed, .bell_valid, .bell_id,
    .resident(ev_resident)
  );

  vlpi_best_rec #(.ID_W(ID_W)) u_rec (
    .clk, .rst_n,
    .eval_en(ev_eval), .eval_id(ev_id), .eval_entry(mem_rdata),
    .load_en(ev_load), .load_id(scan_id), .load_prio(scan_prio),
    .best_id, .best_prio
  );

endmodule

// File: rtl/vlpi_deliver_chk.sv
module vlpi_deliver_chk #(
  parameter int ID_W = 16,
  parameter int AW   = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic            busy,
  input logic            done,
  input logic            bell_valid,
  input logic [ID_W-1:0] bell_id,
  input logic            mem_valid,
  input logic            mem_ready,
  input logic            mem_write,
  input logic [AW-1:0]   mem_addr,
  input logic            scan_req,
  input logic            scan_done,
  input logic [7:0]      best_prio,
  input logic            ev_resident
);

  AST_BELL_NONRES: assert property (@(posedge clk) disable iff (!rst_n)
    bell_valid |-> (!ev_resident && (32'(bell_id) != 32'd1023))); // R6
  AST_BELL_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    bell_valid |=> !bell_valid); // R6
  AST_BELL_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    bell_valid |-> done); // R6
  AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_write))); // R8
  AST_IDLE_NO_MEM: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_valid); // R8
  AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !busy) |=> busy); // R8
  AST_DONE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy); // R8
  AST_SCAN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_req && !scan_done) |=> scan_req); // R5
  AST_REC_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> $stable(best_prio)); // R4

endmodule

bind vlpi_deliver vlpi_deliver_chk #(.ID_W(ID_W), .AW(AW)) u_chk (.*);

// File: tb/tb_vlpi_deliver.sv
`timescale 1ns/1ps
module tb_vlpi_deliver;

  localparam int ID_W = 16;
  localparam int AW   = 32;
  localparam logic [AW-1:0] RES_TBL = 32'h0000;
  localparam logic [AW-1:0] ALT_TBL = 32'h2000;
  localparam logic [AW-1:0] CFG     = 32'h3000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic            req_valid = 1'b0;
  logic [ID_W-1:0] req_id = '0;
  logic [AW-1:0]   req_tbl_addr = '0;
  logic [ID_W-1:0] req_bell_id = '0;
  logic            req_level = 1'b0;
  logic            busy, done, done_changed;
  logic            vpe_valid = 1'b1;
  logic [AW-1:0]   vpe_tbl_addr = RES_TBL;
  logic [AW-1:0]   vcfg_base = CFG;
  logic [4:0]      vcfg_idbits = 5'd13;
  logic            lpi_enable = 1'b1;
  logic            mem_valid, mem_write;
  logic [AW-1:0]   mem_addr;
  logic [7:0]      mem_wdata;
  logic            mem_ready, mem_rvalid;
  logic [7:0]      mem_rdata;
  logic [ID_W-1:0] best_id;
  logic [7:0]      best_prio;
  logic            scan_req, scan_done;
  logic [ID_W-1:0] scan_id;
  logic [7:0]      scan_prio;
  logic            bell_valid;
  logic [ID_W-1:0] bell_id;

  assign scan_id   = 16'd8200;
  assign scan_prio = 8'hA0;

  vlpi_deliver #(.ID_W(ID_W), .AW(AW)) dut (.*);

  logic [7:0] mem [0:16383];
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 16384; i++) mem[i] <= 8'h00;
      mem[CFG + 8]   <= 8'hA1;
      mem[CFG + 108] <= 8'h41;
      mem[CFG + 208] <= 8'h40;
      mem[CFG + 58]  <= 8'h41;
      mem_ready  <= 1'b1;
      mem_rvalid <= 1'b0;
      mem_rdata  <= 8'h00;
    end else begin
      mem_rvalid <= 1'b0;
      mem_ready  <= ~mem_ready;
      if (mem_valid && mem_ready) begin
        if (mem_write) mem[mem_addr[13:0]] <= mem_wdata;
        else begin
          mem_rvalid <= 1'b1;
          mem_rdata  <= mem[mem_addr[13:0]];
        end
      end
    end
  end

  int scan_cnt;
  always @(posedge clk) begin
    if (!rst_n) begin
      scan_cnt  <= 0;
      scan_done <= 1'b0;
    end else begin
      scan_done <= 1'b0;
      if (scan_req && !scan_done) begin
        if (scan_cnt == 2) begin
          scan_done <= 1'b1;
          scan_cnt  <= 0;
        end else scan_cnt <= scan_cnt + 1;
      end
    end
  end

  int checks = 0;
  int errors = 0;

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  logic            o_chg, o_bell, o_scan, o_busy;
  logic [ID_W-1:0] o_bell_id;
  int              o_mem;

  task automatic do_req(input logic [ID_W-1:0] id, input logic [AW-1:0] tbl,
                        input logic lvl, input logic [ID_W-1:0] bell);
    int n;
    @(negedge clk);
    req_id = id; req_tbl_addr = tbl; req_level = lvl; req_bell_id = bell;
    req_valid = 1'b1;
    @(posedge clk); #1;
    req_valid = 1'b0;
    o_busy = busy; o_chg = 1'b0; o_bell = 1'b0; o_scan = 1'b0; o_mem = 0; o_bell_id = '0;
    n = 0;
    while (n < 500) begin
      if (mem_valid && mem_ready) o_mem++;
      if (scan_req) o_scan = 1'b1;
      if (bell_valid) begin o_bell = 1'b1; o_bell_id = bell_id; end
      if (done) begin o_chg = done_changed; break; end
      @(posedge clk); #1;
      n++;
    end
    @(posedge clk); #1;
  endtask

  typedef struct packed {
    logic [ID_W-1:0] id;
    logic            alt;
    logic            lvl;
    logic [ID_W-1:0] bell;
    logic            chg;
    logic            ring;
    logic            scan;
    logic [ID_W-1:0] bid;
    logic [7:0]      bprio;
  } vec_t;

  localparam vec_t VECS [12] = '{
    '{16'd8200,  1'b0, 1'b1, 16'd1023, 1'b1, 1'b0, 1'b0, 16'd8200, 8'hA0},
    '{16'd8200,  1'b0, 1'b1, 16'd1023, 1'b0, 1'b0, 1'b0, 16'd8200, 8'hA0},
    '{16'd8300,  1'b0, 1'b1, 16'd1023, 1'b1, 1'b0, 1'b0, 16'd8300, 8'h40},
    '{16'd8400,  1'b0, 1'b1, 16'd1023, 1'b1, 1'b0, 1'b0, 16'd8300, 8'h40},
    '{16'd8250,  1'b0, 1'b1, 16'd1023, 1'b1, 1'b0, 1'b0, 16'd8250, 8'h40},
    '{16'd8300,  1'b0, 1'b0, 16'd1023, 1'b1, 1'b0, 1'b0, 16'd8250, 8'h40},
    '{16'd8250,  1'b0, 1'b0, 16'd1023, 1'b1, 1'b0, 1'b1, 16'd8200, 8'hA0},
    '{16'd16384, 1'b0, 1'b1, 16'd9000, 1'b0, 1'b0, 1'b0, 16'd8200, 8'hA0},
    '{16'd8200,  1'b1, 1'b1, 16'd9000, 1'b1, 1'b1, 1'b0, 16'd8200, 8'hA0},
    '{16'd8200,  1'b1, 1'b0, 16'd9000, 1'b1, 1'b0, 1'b0, 16'd8200, 8'hA0},
    '{16'd8201,  1'b1, 1'b1, 16'd1023, 1'b1, 1'b0, 1'b0, 16'd8200, 8'hA0},
    '{16'd8201,  1'b1, 1'b1, 16'd9001, 1'b0, 1'b1, 1'b0, 16'd8200, 8'hA0}
  };

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    #1;
    chk("R9", "busy at reset", busy, 0);
    chk("R9", "mem_valid at reset", mem_valid, 0);
    chk("R9", "scan_req at reset", scan_req, 0);
    chk("R9", "bell_valid at reset", bell_valid, 0);
    chk("R9", "best_prio at reset", best_prio, 8'hFF);
    chk("R9", "best_id at reset", best_id, 0);
    @(negedge clk); rst_n = 1'b1;
    repeat (2) @(posedge clk);

    foreach (VECS[k]) begin
      do_req(VECS[k].id, VECS[k].alt ? ALT_TBL : RES_TBL, VECS[k].lvl, VECS[k].bell);
      chk("R8", $sformatf("v%0d busy after accept", k), o_busy, 1);
      chk("R3", $sformatf("v%0d done_changed", k), o_chg, VECS[k].chg);
      chk("R6", $sformatf("v%0d doorbell", k), o_bell, VECS[k].ring);
      if (VECS[k].ring) chk("R6", $sformatf("v%0d doorbell id", k), o_bell_id, VECS[k].bell);
      chk("R5", $sformatf("v%0d rescan request", k), o_scan, VECS[k].scan);
      chk("R4", $sformatf("v%0d best_id", k), best_id, VECS[k].bid);
      chk("R4", $sformatf("v%0d best_prio", k), best_prio, VECS[k].bprio);
      if (k == 7) chk("R2", "dropped request memory accesses", o_mem, 0);
    end

    chk("R3", "resident byte for 8200", mem[1025], 8'h01);
    chk("R3", "resident byte for 8250 cleared", mem[1031], 8'h00);
    chk("R3", "resident byte for 8300 cleared", mem[1037], 8'h00);
    chk("R3", "resident byte for 8400", mem[1050], 8'h01);
    chk("R2", "byte at 16384/8 untouched", mem[2048], 8'h00);
    chk("R7", "non-resident table byte", mem[ALT_TBL + 1025], 8'h02);

    vpe_valid = 1'b0;
    do_req(16'd8210, RES_TBL, 1'b1, 16'd9100);
    chk("R1", "invalid schedule rings doorbell", o_bell, 1);
    chk("R1", "doorbell id", o_bell_id, 16'd9100);
    chk("R7", "bit flipped while not resident", o_chg, 1);
    chk("R1", "record untouched best_id", best_id, 16'd8200);
    chk("R1", "record untouched best_prio", best_prio, 8'hA0);
    chk("R7", "byte for 8210", mem[1026], 8'h04);
    vpe_valid = 1'b1;

    lpi_enable = 1'b0;
    do_req(16'd8212, ALT_TBL, 1'b1, 16'd9200);
    chk("R6", "no doorbell with interrupts disabled", o_bell, 0);
    chk("R3", "bit changed with interrupts disabled", o_chg, 1);
    lpi_enable = 1'b1;

    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(posedge clk); #1;
    chk("R9", "best_prio after second reset", best_prio, 8'hFF);
    chk("R9", "best_id after second reset", best_id, 0);
    chk("R9", "busy after second reset", busy, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule